// File: doc/BRIEF.md
# Spilling Return Stack

This block is a small return stack kept in registers next to the sequencer. With its extension turned off it is a plain last-in-first-out store with a fixed number of slots. With the extension turned on it can grow past that number: when a push arrives and every on-chip slot is occupied, the oldest on-chip entry is first written out to data memory. When a pull leaves the on-chip file with no entries while spilled entries remain, the most recently spilled entry is read back in before the pull completes. Data memory is reached through a request/ready port that carries a bit choosing one of two memory spaces.

A programmable size limit bounds the total depth in extension mode. Three sticky status bits record the first spill, an over-limit push and a pull from an empty stack. The last two raise a one-cycle, non-maskable stack-error pulse when they first become set. A control write loads the enable, the space select and the size limit, and it clears the status bits. Callers issue single-cycle requests, watch `busy`, and take results when `op_done` pulses.

Top module: `hw_stack_ext`

## Requirements
- R1: After reset, `sp` is 0, all three flags and `stack_err` are 0, `busy` and `mem_req` are 0, and extension mode is off.
- R2: Pushes and pulls that need no memory transfer complete with `op_done` one cycle after the request, and pulls return the values in last-in-first-out order.
- R3: With extension off, a push into a full file and a pull from an empty file leave `sp` unchanged. The empty pull returns 0. The flags stay 0 and `mem_req` stays 0.
- R4: With extension on and the file full, a push below the limit issues a memory write (`mem_we`=1) of the oldest on-chip entry at address equal to the number of entries spilled so far. `sp` counts the total depth past the file size.
- R5: With extension on, a pull that takes the last on-chip entry while spilled entries exist issues a memory read at address (spilled count − 1). The pull returns the top value, and later pulls continue in last-in-first-out order through the refilled entries.
- R6: `flag_wrap` sets when the first spill starts and stays set.
- R7: With extension on, a push while `sp` equals the size limit sets `flag_ovf` and is discarded, so `sp` does not change.
- R8: With extension on, a pull while `sp` is 0 sets `flag_unf` and returns 0.
- R9: `stack_err` pulses for one cycle exactly when `flag_ovf` or `flag_unf` changes from 0 to 1. A fault that repeats while its flag is already set gives no pulse.
- R10: A control write takes effect on the next clock and clears all three flags. If a flag-setting event happens in the same cycle as the clearing write, the flag ends up set.
- R11: `mem_ysel` equals the space-select value (0 selects X, 1 selects Y) that is in force when the transfer starts.
- R12: Only one memory transfer is outstanding at a time. `mem_req` and its address are held until `mem_ready`, `op_done` waits for the transfer to finish, and a request made while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_req | input | 1 | One-cycle operation request, taken when not busy |
| op_pull | input | 1 | 1 = pull, 0 = push |
| op_wdata | input | DW | Push value |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | DW | Pulled value, valid with op_done |
| busy | output | 1 | A memory transfer is in progress |
| ctl_we | input | 1 | Control write strobe |
| ctl_ext_en | input | 1 | Extension enable to load |
| ctl_ysel | input | 1 | Memory space select to load (0 X, 1 Y) |
| ctl_size | input | SPW | Size limit to load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = spill write, 0 = refill read |
| mem_ysel | output | 1 | Memory space of the transfer |
| mem_addr | output | SPW | Extension slot address |
| mem_wdata | output | DW | Spilled value |
| mem_ready | input | 1 | Transfer completes at this edge |
| mem_rdata | input | DW | Refill value, sampled with mem_ready |
| sp | output | SPW | Total stack depth |
| flag_wrap | output | 1 | Sticky first-spill flag |
| flag_ovf | output | 1 | Sticky over-limit flag |
| flag_unf | output | 1 | Sticky empty-pull flag |
| stack_err | output | 1 | Non-maskable stack-error pulse |

## Verification
The bench builds the block with a four-slot file, 8-bit data and a 5-bit pointer. With these values a handful of pushes is enough to fill the file, spill, reach the size limit and drain back through refills. Long random push-heavy and pull-heavy runs then cross every full, empty and limit boundary many times, with memory latencies of 0 to 3 cycles, under size limits both above and below the file size and in both memory spaces. A running model in the bench predicts every returned value, pointer value, flag, error pulse and memory address.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
// Shared types for the spilling return stack.
package stk_pkg;
    // Sequencer state: idle, spill write outstanding, refill read outstanding.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_file.sv
`timescale 1ns/1ps
// On-chip entry storage: one write port, two asynchronous read ports
// (top and oldest entry). Assumes DEPTH is a power of two so indices wrap.
module stk_file #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] slot_q [DEPTH];

    // Write one slot per cycle; contents need no reset.
    always_ff @(posedge clk) begin
        if (we) slot_q[waddr] <= wdata;
    end

    assign rdata_a = slot_q[raddr_a];
    assign rdata_b = slot_q[raddr_b];
endmodule

// File: rtl/stk_flags.sv
`timescale 1ns/1ps
// Sticky status bits {empty-pull, over-limit, first-spill} and the
// non-maskable error pulse. Set events win over a same-cycle clear.
module stk_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wrap_ev,
    input  logic       ovf_ev,
    input  logic       unf_ev,
    output logic [2:0] flg,
    output logic       err
);
    logic [2:0] flg_q;
    logic       err_q;
    logic [2:0] ev;

    assign ev = {unf_ev, ovf_ev, wrap_ev};

    // Hold, clear on control write, and OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= 3'b000;
        else        flg_q <= (clr ? 3'b000 : flg_q) | ev;
    end

    // Pulse the error only on a 0-to-1 change of a fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (ev[1] & ~flg_q[1]) | (ev[2] & ~flg_q[2]);
    end

    assign flg = flg_q;
    assign err = err_q;

    a_r9_err_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($rose(flg_q[1]) || $rose(flg_q[2])));
    a_r9_rise_gives_err: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flg_q[1]) || $rose(flg_q[2])) |-> err_q);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(flg_q) & ~flg_q) == 3'b000));
endmodule

// File: rtl/hw_stack_ext.sv
`timescale 1ns/1ps
// Return stack with an on-chip file of DEPTH entries that spills its oldest
// entries to data memory when extension mode is on. Assumes DEPTH is a power
// of two, SPW > log2(DEPTH), and that the enable is only changed while empty.
module hw_stack_ext
    import stk_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int SPW   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_req,
    input  logic           op_pull,
    input  logic [DW-1:0]  op_wdata,
    output logic           op_done,
    output logic [DW-1:0]  op_rdata,
    output logic           busy,
    input  logic           ctl_we,
    input  logic           ctl_ext_en,
    input  logic           ctl_ysel,
    input  logic [SPW-1:0] ctl_size,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_ysel,
    output logic [SPW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic [SPW-1:0] sp,
    output logic           flag_wrap,
    output logic           flag_ovf,
    output logic           flag_unf,
    output logic           stack_err
);
    localparam int IW = $clog2(DEPTH);
    localparam int FW = IW + 1;
    localparam logic [IW-1:0]  ONE_I = IW'(1);
    localparam logic [FW-1:0]  ONE_F = FW'(1);
    localparam logic [FW-1:0]  FULL  = FW'(DEPTH);
    localparam logic [SPW-1:0] ONE_S = SPW'(1);

    stk_state_e     st_q;
    logic [IW-1:0]  top_q;
    logic [FW-1:0]  fill_q;
    logic [SPW-1:0] ep_q;
    logic [DW-1:0]  xfer_q;
    logic           spc_q;
    logic           done_q;
    logic [DW-1:0]  rdata_q;
    logic           en_q;
    logic           ysel_q;
    logic [SPW-1:0] size_q;

    logic           accept, is_full, is_empty;
    logic           ovf_ev, unf_ev, spill_go, fill_go, push_go, pop_go;
    logic           spill_end, fill_end;
    logic           f_we;
    logic [IW-1:0]  f_waddr, bot_idx;
    logic [DW-1:0]  f_wdata, rd_top, rd_bot;
    logic [SPW-1:0] sp_w;
    logic [2:0]     flg;

    // Decode the accepted request into exactly one action.
    always_comb begin
        sp_w      = ep_q + SPW'(fill_q);
        accept    = op_req && (st_q == ST_IDLE);
        is_full   = (fill_q == FULL);
        is_empty  = (fill_q == '0);
        ovf_ev    = accept && !op_pull && en_q && (sp_w == size_q);
        unf_ev    = accept && op_pull && en_q && (sp_w == '0);
        spill_go  = accept && !op_pull && en_q && !ovf_ev && is_full;
        fill_go   = accept && op_pull && en_q && (fill_q == ONE_F) && (ep_q != '0);
        push_go   = accept && !op_pull && !is_full && !ovf_ev;
        pop_go    = accept && op_pull && !is_empty && !fill_go && !unf_ev;
        spill_end = (st_q == ST_SPILL) && mem_ready;
        fill_end  = (st_q == ST_FILL) && mem_ready;
        bot_idx   = top_q - IW'(fill_q) + ONE_I;
    end

    // Select the single file write of this cycle.
    always_comb begin
        f_we    = push_go || spill_end || fill_end;
        f_waddr = fill_end ? (top_q - ONE_I) : (top_q + ONE_I);
        f_wdata = fill_end ? mem_rdata : (spill_end ? xfer_q : op_wdata);
    end

    stk_file #(.DW(DW), .DEPTH(DEPTH)) u_file (
        .clk     (clk),
        .we      (f_we),
        .waddr   (f_waddr),
        .wdata   (f_wdata),
        .raddr_a (top_q),
        .raddr_b (bot_idx),
        .rdata_a (rd_top),
        .rdata_b (rd_bot)
    );

    stk_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl_we),
        .wrap_ev (spill_go),
        .ovf_ev  (ovf_ev),
        .unf_ev  (unf_ev),
        .flg     (flg),
        .err     (stack_err)
    );

    // Transfer sequencer: one memory access outstanding at most.
    always_ff @(posedge clk) begin
        if (!rst_n)                     st_q <= ST_IDLE;
        else if (spill_go)              st_q <= ST_SPILL;
        else if (fill_go)               st_q <= ST_FILL;
        else if (spill_end || fill_end) st_q <= ST_IDLE;
    end

    // Top index, on-chip count and spilled count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q  <= '0;
            fill_q <= '0;
            ep_q   <= '0;
        end else begin
            if (push_go || spill_end)    top_q <= top_q + ONE_I;
            else if (pop_go || fill_end) top_q <= top_q - ONE_I;
            if (push_go)                 fill_q <= fill_q + ONE_F;
            else if (pop_go)             fill_q <= fill_q - ONE_F;
            if (spill_end)               ep_q <= ep_q + ONE_S;
            else if (fill_end)           ep_q <= ep_q - ONE_S;
        end
    end

    // Park the pending push value or popped value, and the transfer space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= '0;
            spc_q  <= 1'b0;
        end else if (spill_go || fill_go) begin
            xfer_q <= spill_go ? op_wdata : rd_top;
            spc_q  <= ysel_q;
        end
    end

    // Completion pulse and returned value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= (accept && !spill_go && !fill_go) || spill_end || fill_end;
            if (pop_go)                 rdata_q <= rd_top;
            else if (fill_end)          rdata_q <= xfer_q;
            else if (accept && op_pull) rdata_q <= '0;
        end
    end

    // Control register: enable, space select and size limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ysel_q <= 1'b0;
            size_q <= '1;
        end else if (ctl_we) begin
            en_q   <= ctl_ext_en;
            ysel_q <= ctl_ysel;
            size_q <= ctl_size;
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (st_q == ST_SPILL);
    assign mem_ysel  = spc_q;
    assign mem_addr  = (st_q == ST_SPILL) ? ep_q : (ep_q - ONE_S);
    assign mem_wdata = rd_bot;
    assign op_done   = done_q;
    assign op_rdata  = rdata_q;
    assign sp        = sp_w;
    assign flag_wrap = flg[0];
    assign flag_ovf  = flg[1];
    assign flag_unf  = flg[2];

    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_ysel)));
    a_r12_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> !op_done);
    a_r3_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !mem_req) |=> !mem_req);
    a_r7_sp_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> (sp == $past(sp)));
    a_r8_sp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf_ev |=> (sp == '0));
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FULL);
endmodule

// File: tb/sim_hw_stack_ext.sv
`timescale 1ns/1ps
module sim_hw_stack_ext;
    localparam int DW = 8, DEPTH = 4, SPW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic op_req = 0, op_pull = 0, op_done, busy;
    logic [DW-1:0] op_wdata = '0, op_rdata;
    logic ctl_we = 0, ctl_ext_en = 0, ctl_ysel = 0;
    logic [SPW-1:0] ctl_size = '0;
    logic mem_req, mem_we, mem_ysel, mem_ready = 0;
    logic [SPW-1:0] mem_addr, sp;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic flag_wrap, flag_ovf, flag_unf, stack_err;

    hw_stack_ext #(.DW(DW), .DEPTH(DEPTH), .SPW(SPW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_pull(op_pull),
        .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata), .busy(busy),
        .ctl_we(ctl_we), .ctl_ext_en(ctl_ext_en), .ctl_ysel(ctl_ysel), .ctl_size(ctl_size),
        .mem_req(mem_req), .mem_we(mem_we), .mem_ysel(mem_ysel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .sp(sp), .flag_wrap(flag_wrap), .flag_ovf(flag_ovf), .flag_unf(flag_unf),
        .stack_err(stack_err)
    );

    int nchk = 0, nfail = 0;
    int cyc = 0;
    int err_total = 0, exp_err_total = 0;

    // Memory model with programmable latency, logging each transfer.
    logic [DW-1:0] memx [32];
    logic [DW-1:0] memy [32];
    int lat = 0, wcnt = 0, xfer_n = 0;
    int last_addr = 0, last_we = 0, last_ys = 0, last_wd = 0;
    always @(negedge clk) begin
        if (mem_req && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                wcnt = 0;
                xfer_n++;
                last_addr = int'(mem_addr);
                last_we = int'(mem_we);
                last_ys = int'(mem_ysel);
                last_wd = int'(mem_wdata);
                if (mem_we) begin
                    if (mem_ysel) memy[mem_addr] = mem_wdata;
                    else          memx[mem_addr] = mem_wdata;
                end else begin
                    mem_rdata = mem_ysel ? memy[mem_addr] : memx[mem_addr];
                end
            end else wcnt++;
        end else mem_ready = 1'b0;
    end

    always @(negedge clk) if (rst_n && stack_err) err_total++;

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL R12 watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model state.
    int ref_stk [64];
    int ref_fill = 0, ref_ep = 0;
    bit en = 0, ys = 0;
    int size = 31;
    bit rw = 0, ro = 0, ru = 0;

    task automatic model_step(input bit pull, input int d, output string tag, output int erd,
                              output bit ex, output bit ewe, output int eaddr,
                              output int ewd, output bit eerr);
        int n;
        n = ref_ep + ref_fill;
        tag = "R2"; erd = 0; ex = 0; ewe = 0; eaddr = 0; ewd = 0; eerr = 0;
        if (!pull) begin
            if (en && n == size) begin
                tag = "R7"; eerr = !ro; ro = 1;
            end else if (ref_fill == DEPTH) begin
                if (en) begin
                    tag = "R4"; ex = 1; ewe = 1; eaddr = ref_ep; ewd = ref_stk[ref_ep];
                    rw = 1; ref_ep++; ref_stk[n] = d;
                end else tag = "R3";
            end else begin
                ref_fill++; ref_stk[n] = d;
            end
        end else begin
            if (en && n == 0) begin
                tag = "R8"; eerr = !ru; ru = 1;
            end else if (en && ref_fill == 1 && ref_ep > 0) begin
                tag = "R5"; ex = 1; ewe = 0; eaddr = ref_ep - 1;
                ref_ep--; erd = ref_stk[n-1];
            end else if (ref_fill == 0) begin
                tag = "R3";
            end else begin
                ref_fill--; erd = ref_stk[n-1];
            end
        end
        if (eerr) exp_err_total++;
    endtask

    task automatic wait_done();
        int c;
        c = 0;
        while (!op_done && c < 40) begin
            @(negedge clk);
            c++;
        end
        chk(op_done, "R12 completion", int'(op_done), 1);
    endtask

    task automatic run_op(input bit pull, input int d);
        string tag; int erd, eaddr, ewd, x0; bit ex, ewe, eerr;
        model_step(pull, d, tag, erd, ex, ewe, eaddr, ewd, eerr);
        x0 = xfer_n;
        @(negedge clk);
        op_req = 1; op_pull = pull; op_wdata = DW'(d);
        @(negedge clk);
        op_req = 0;
        wait_done();
        if (pull) chk(int'(op_rdata) == erd, {tag, " rdata"}, int'(op_rdata), erd);
        chk(int'(sp) == ref_ep + ref_fill, {tag, " sp"}, int'(sp), ref_ep + ref_fill);
        chk(flag_wrap == rw, "R6 wrap flag", int'(flag_wrap), int'(rw));
        chk(flag_ovf == ro, "R7 ovf flag", int'(flag_ovf), int'(ro));
        chk(flag_unf == ru, "R8 unf flag", int'(flag_unf), int'(ru));
        chk(stack_err == eerr, "R9 err pulse", int'(stack_err), int'(eerr));
        chk(xfer_n - x0 == int'(ex), "R12 transfer count", xfer_n - x0, int'(ex));
        if (ex && xfer_n - x0 == 1) begin
            chk(last_addr == eaddr, {tag, " mem addr"}, last_addr, eaddr);
            chk(last_we == int'(ewe), {tag, " mem dir"}, last_we, int'(ewe));
            chk(last_ys == int'(ys), "R11 mem space", last_ys, int'(ys));
            if (ewe) chk(last_wd == ewd, "R4 spill data", last_wd, ewd);
        end
    endtask

    task automatic ctl_write(input bit e, input bit y, input int s);
        @(negedge clk);
        ctl_we = 1; ctl_ext_en = e; ctl_ysel = y; ctl_size = SPW'(s);
        @(negedge clk);
        ctl_we = 0;
        en = e; ys = y; size = s; rw = 0; ro = 0; ru = 0;
        chk({flag_wrap, flag_ovf, flag_unf} == 3'b000, "R10 clear",
            int'({flag_wrap, flag_ovf, flag_unf}), 0);
    endtask

    task automatic drain();
        while (ref_ep + ref_fill > 0) run_op(1, 0);
    endtask

    task automatic random_phases(input int nph);
        logic [15:0] lf;
        bit pull;
        lf = 16'hACE1 ^ 16'(nph * 977 + size);
        for (int ph = 0; ph < nph; ph++) begin
            for (int i = 0; i < 100; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                pull = (ph % 2 == 0) ? (lf[1:0] == 2'd0) : (lf[1:0] != 2'd0);
                lat = int'(lf[4:3]);
                run_op(pull, int'(lf[15:8]));
            end
        end
        drain();
    endtask

    initial begin
        string tag; int erd, eaddr, ewd; bit ex, ewe, eerr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sp == '0, "R1 sp", int'(sp), 0);
        chk({flag_wrap, flag_ovf, flag_unf, stack_err} == 4'b0, "R1 flags",
            int'({flag_wrap, flag_ovf, flag_unf, stack_err}), 0);
        chk(!busy && !mem_req && !op_done, "R1 idle", int'({busy, mem_req, op_done}), 0);

        // R2/R3 plain mode: fill, overfill, drain, overdrain
        for (int i = 0; i < DEPTH + 2; i++) run_op(0, 16 + i);
        for (int i = 0; i < DEPTH + 2; i++) run_op(1, 0);
        chk(xfer_n == 0, "R3 no transfers in plain mode", xfer_n, 0);

        // R4..R9 directed climb to the limit and back down
        ctl_write(1, 0, 20);
        lat = 1;
        for (int i = 0; i < 22; i++) run_op(0, 100 + i);
        for (int i = 0; i < 22; i++) run_op(1, 0);

        // R10 event in the same cycle as a clearing write: event wins
        ctl_write(1, 0, 20);
        run_op(1, 0);
        @(negedge clk);
        ctl_we = 1; ctl_ext_en = 1; ctl_ysel = 0; ctl_size = SPW'(20);
        op_req = 1; op_pull = 1;
        @(negedge clk);
        ctl_we = 0; op_req = 0;
        wait_done();
        chk(flag_unf == 1'b1, "R10 set wins over clear", int'(flag_unf), 1);
        chk(stack_err == 1'b0, "R9 no pulse when already set", int'(stack_err), 0);

        // R12 request during a spill is ignored
        ctl_write(1, 1, 31);
        for (int i = 0; i < DEPTH; i++) run_op(0, 60 + i);
        lat = 3;
        model_step(0, 77, tag, erd, ex, ewe, eaddr, ewd, eerr);
        @(negedge clk);
        op_req = 1; op_pull = 0; op_wdata = 8'd77;
        @(negedge clk);
        op_req = 0;
        @(negedge clk);
        chk(busy == 1'b1, "R12 busy during spill", int'(busy), 1);
        op_req = 1; op_wdata = 8'd88;
        @(negedge clk);
        op_req = 0;
        wait_done();
        @(negedge clk);
        chk(int'(sp) == DEPTH + 1, "R12 ignored request", int'(sp), DEPTH + 1);
        drain();

        // Random sweeps across limits, latencies and spaces (R2..R11)
        ctl_write(1, 0, 12);
        random_phases(4);
        ctl_write(1, 1, 31);
        random_phases(4);
        ctl_write(1, 0, 3);
        random_phases(2);

        @(negedge clk);
        chk(err_total == exp_err_total, "R9 total error pulses", err_total, exp_err_total);
        finish_run();
    end
endmodule